// File: doc/BRIEF.md
# Glitchless Output-Divider Change Gate

This block sits after the output divider of a clock synthesizer. It turns the fast oscillator-side clock into a divided output clock. When software writes a new divide value while the synthesizer is running, the block does not let the new value take effect in the middle of a phase. It waits until the output is in its low phase and stops the divider there. It then holds the output low for a set number of reference-clock periods, either 3 or 12. After that it loads the new divide value, restarts the divider from zero and clears its busy flag once the first complete output cycle at the new rate has finished.

When the synthesizer is not running, a new divide value is taken straight away, with no gating and no busy indication. The reference clock is sampled as data in the fast domain, so the whole block runs on one clock.

Top module: `odg_gate`

## Requirements
- R1: During reset and just after it, the output clock and the busy flag are low. The first low phase after reset lasts RESET_DIV+1 fast-clock cycles (default RESET_DIV = 3, so 4 cycles).
- R2: In normal running with divide field value d, each high phase and each low phase of the output lasts d+1 fast-clock cycles.
- R3: While the active input is low, a new divide field value is loaded directly. The busy flag stays low. Once the block is active again, the output phases have the new length.
- R4: A change of the divide field while the active input is high raises the busy flag one fast-clock cycle after the change is seen.
- R5: After a change is seen while active, the output finishes any high phase it is in. It then stays low for the whole hold, and the busy flag stays high throughout.
- R6: The gated low interval spans 3 reference-clock rising edges when the long-hold input is 0, and 12 when it is 1. A low interval of L cycles satisfies (H-1)*P+d <= L <= H*P+d+8, where H is the hold count, P is the reference period in fast cycles and d is the new divide value.
- R7: The new divide value goes into the divider only while the output is gated. The first high phase after restart lasts exactly d+1 cycles. No output phase is ever shorter than the smaller of the old and new half periods.
- R8: The busy flag stays high through the first full output cycle after restart. It falls on the same fast-clock edge as the falling edge that ends that cycle.
- R9: A further divide field change during the gating wait or hold restarts the hold count and uses the latest value. The remaining low interval is measured from the second change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vcoClk | input | 1 | Fast oscillator-side clock; all logic runs on it |
| refClk | input | 1 | Reference clock, sampled and edge-detected; must be slower than vcoClk/4 |
| rstN | input | 1 | Asynchronous active-low reset |
| pllActive | input | 1 | High while the synthesizer is running; enables gated changes |
| longHold | input | 1 | Selects the hold length: 0 gives 3 reference periods, 1 gives 12 |
| divField | input | DIV_W | Requested output divide value d; each half period is d+1 fast cycles |
| pllClk | output | 1 | Divided, glitch-free output clock |
| gateBusy | output | 1 | High from a seen active change until the first full output cycle after restart |

## Verification
The bench sweeps every divide value with direct loads and checks both phase lengths. If the direct-load path were gated, or took effect mid-phase, the bench would see a spurious busy flag or a wrong phase length. For active changes it covers both hold lengths, changes that arrive while the output is high and while it is low, and a second change part-way through a hold. A design that stopped in a high phase, counted the wrong number of reference edges, or kept the first of two values would show a short or long gated low interval, or a wrong first high phase. A background monitor compares every output run length against the smallest half period in play, so any runt pulse at the stop or restart is caught. The busy flag is checked at both ends: it must rise one cycle after the change and fall exactly with the end of the first new cycle.

// File: rtl/odg_pkg.sv
package odg_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_WAITLOW = 2'd1,
    ST_HOLD    = 2'd2,
    ST_RESTART = 2'd3
  } gateState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic freeze;      // hold the divider counter and output level
    logic loadDiv;     // gated load of the new divide value, counter cleared
    logic directLoad;  // ungated load while inactive, counter keeps running
  } gateCtrl_t;

endpackage

// File: rtl/odg_datapath.sv
module odg_datapath
  import odg_pkg::*;
#(
  parameter int DIV_W     = 3,
  parameter int RESET_DIV = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  gateCtrl_t        ctrl,
  input  logic [DIV_W-1:0] loadVal,
  output logic             divClk,
  output logic             fallTick
);

  localparam int RUN_W = 16;

  logic [DIV_W-1:0] curDiv;
  logic [DIV_W-1:0] cnt;
  logic             terminal;

  assign terminal = (cnt >= curDiv);
  assign fallTick = divClk && terminal && !ctrl.freeze && !ctrl.loadDiv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curDiv <= DIV_W'(RESET_DIV);
      cnt    <= '0;
      divClk <= 1'b0;
    end else if (ctrl.loadDiv) begin
      curDiv <= loadVal;
      cnt    <= '0;
    end else begin
      if (ctrl.directLoad) curDiv <= loadVal;
      if (!ctrl.freeze) begin
        if (terminal) begin
          cnt    <= '0;
          divClk <= ~divClk;
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end
    end
  end

  // Run-length tracker for the phase-length check
  logic [RUN_W-1:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (!ctrl.freeze && !ctrl.loadDiv && terminal) runLen <= '0;
    else if (runLen != {RUN_W{1'b1}}) runLen <= runLen + RUN_W'(1);
  end

  AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.freeze && !ctrl.loadDiv && terminal) |-> (runLen >= RUN_W'(curDiv))); // R7

  AST_FREEZE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.freeze |-> !divClk); // R5

  AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadDiv |-> (ctrl.freeze && !divClk)); // R7

  AST_RESTART_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadDiv |=> !divClk); // R7

endmodule

// File: rtl/odg_ctrl.sv
module odg_ctrl
  import odg_pkg::*;
#(
  parameter int DIV_W      = 3,
  parameter int RESET_DIV  = 3,
  parameter int SHORT_HOLD = 3,
  parameter int LONG_HOLD  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refClk,
  input  logic             pllActive,
  input  logic             longHold,
  input  logic [DIV_W-1:0] divField,
  input  logic             divClk,
  input  logic             fallTick,
  output gateCtrl_t        ctrl,
  output logic [DIV_W-1:0] loadVal,
  output logic             busy
);

  localparam int HC_W = $clog2(LONG_HOLD + 1);

  gateState_t       state;
  logic [DIV_W-1:0] wantDiv;
  logic [HC_W-1:0]  holdCnt;
  logic [2:0]       refSync;
  logic             refTick;
  logic [HC_W-1:0]  holdTarget;
  logic             fieldChanged;
  logic             holdLast;

  assign refTick      = refSync[1] & ~refSync[2];
  assign holdTarget   = longHold ? HC_W'(LONG_HOLD) : HC_W'(SHORT_HOLD);
  assign fieldChanged = (divField != wantDiv);
  assign holdLast     = (holdCnt >= holdTarget - HC_W'(1));
  assign busy         = (state != ST_RUN);

  always_comb begin
    ctrl.freeze     = pllActive &&
                      ((state == ST_WAITLOW && !divClk) || state == ST_HOLD);
    ctrl.loadDiv    = pllActive && state == ST_HOLD && refTick && holdLast &&
                      !fieldChanged;
    ctrl.directLoad = !pllActive && (fieldChanged || state != ST_RUN);
    loadVal         = ctrl.directLoad ? divField : wantDiv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refSync <= '0;
    else       refSync <= {refSync[1:0], refClk};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_RUN;
      wantDiv <= DIV_W'(RESET_DIV);
      holdCnt <= '0;
    end else if (!pllActive) begin
      state   <= ST_RUN;
      wantDiv <= divField;
      holdCnt <= '0;
    end else if (fieldChanged) begin
      wantDiv <= divField;
      holdCnt <= '0;
      if (state == ST_RUN || state == ST_RESTART) state <= ST_WAITLOW;
    end else begin
      case (state)
        ST_WAITLOW: if (!divClk) begin
          state   <= ST_HOLD;
          holdCnt <= '0;
        end
        ST_HOLD: if (refTick) begin
          if (holdLast) begin
            state   <= ST_RESTART;
            holdCnt <= '0;
          end else begin
            holdCnt <= holdCnt + HC_W'(1);
          end
        end
        ST_RESTART: if (fallTick) state <= ST_RUN;
        default: state <= ST_RUN;
      endcase
    end
  end

  AST_ACTIVE_CHANGE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (pllActive && fieldChanged) |=> busy); // R4

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |-> (holdCnt < holdTarget)); // R6

  AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(fallTick || !pllActive)); // R8

  AST_HOLD_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (pllActive && fieldChanged && state == ST_HOLD) |=> (state == ST_HOLD)); // R9

endmodule

// File: rtl/odg_gate.sv
module odg_gate
  import odg_pkg::*;
#(
  parameter int DIV_W      = 3,
  parameter int RESET_DIV  = 3,
  parameter int SHORT_HOLD = 3,
  parameter int LONG_HOLD  = 12
) (
  input  logic             vcoClk,
  input  logic             refClk,
  input  logic             rstN,
  input  logic             pllActive,
  input  logic             longHold,
  input  logic [DIV_W-1:0] divField,
  output logic             pllClk,
  output logic             gateBusy
);

  gateCtrl_t        ctrl;
  logic [DIV_W-1:0] loadVal;
  logic             divClk;
  logic             fallTick;

  odg_ctrl #(
    .DIV_W(DIV_W), .RESET_DIV(RESET_DIV),
    .SHORT_HOLD(SHORT_HOLD), .LONG_HOLD(LONG_HOLD)
  ) u_ctrl (
    .clk(vcoClk), .rstN(rstN), .refClk(refClk), .pllActive(pllActive),
    .longHold(longHold), .divField(divField), .divClk(divClk),
    .fallTick(fallTick), .ctrl(ctrl), .loadVal(loadVal), .busy(gateBusy)
  );

  odg_datapath #(
    .DIV_W(DIV_W), .RESET_DIV(RESET_DIV)
  ) u_dp (
    .clk(vcoClk), .rstN(rstN), .ctrl(ctrl), .loadVal(loadVal),
    .divClk(divClk), .fallTick(fallTick)
  );

  assign pllClk = divClk;

endmodule

// File: tb/sim_odg_gate.sv
module sim_odg_gate;

  localparam int DIV_W = 3;
  localparam int RDIV  = 3;
  localparam int SHOLD = 3;
  localparam int LHOLD = 12;
  localparam int REFP  = 8;

  logic clk = 1'b0;
  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic pllActive = 1'b1;
  logic longHold = 1'b0;
  logic [DIV_W-1:0] divField = DIV_W'(RDIV);
  logic pllClk;
  logic gateBusy;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int curDiv = RDIV;
  int minHalf = 1;
  int runtErr = 0;
  int runLen = 0;
  logic prevClk = 1'b0;

  odg_gate #(.DIV_W(DIV_W), .RESET_DIV(RDIV), .SHORT_HOLD(SHOLD), .LONG_HOLD(LHOLD)) u0 (
    .vcoClk(clk), .refClk(refClk), .rstN(rstN), .pllActive(pllActive),
    .longHold(longHold), .divField(divField), .pllClk(pllClk), .gateBusy(gateBusy)
  );

  always #10 clk = ~clk;
  initial begin #7; forever #80 refClk = ~refClk; end

  always @(negedge clk) begin
    if (rstN) begin
      if (pllClk !== prevClk) begin
        if (runLen < minHalf) runtErr++;
        runLen = 1;
      end else runLen++;
      prevClk = pllClk;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive;
    @(posedge clk); #5;
  endtask

  task automatic countLevel(logic lvl, output int n, output int busyLow);
    n = 0; busyLow = 0;
    while (pllClk === lvl && n < 1000) begin
      n++;
      if (gateBusy !== 1'b1) busyLow++;
      @(negedge clk);
    end
  endtask

  task automatic waitLevel(logic lvl);
    int g = 0;
    while (pllClk !== lvl && g < 200) begin g++; @(negedge clk); end
  endtask

  // Measure restart: high run of d+1 with busy high, busy low at fall, low run d+1
  task automatic checkRestart(int d);
    int h, bl, l;
    countLevel(1'b1, h, bl);
    chk(h == d + 1, "R7 first high after restart", h, d + 1);
    chk(bl == 0, "R8 busy high during first cycle", bl, 0);
    chk(gateBusy === 1'b0, "R8 busy clears with first fall", int'(gateBusy), 0);
    countLevel(1'b0, l, bl);
    chk(l == d + 1, "R2 low phase after restart", l, d + 1);
  endtask

  task automatic activeChange(int nd, bit lng);
    int h = lng ? LHOLD : SHOLD;
    int l, bl, lo, hi;
    minHalf = ((curDiv < nd) ? curDiv : nd) + 1;
    longHold = lng;
    drive; divField = DIV_W'(nd);
    @(negedge clk);
    @(negedge clk);
    chk(gateBusy === 1'b1, "R4 busy after active change", int'(gateBusy), 1);
    waitLevel(1'b0);
    countLevel(1'b0, l, bl);
    lo = (h - 1) * REFP + nd;
    hi = h * REFP + nd + 8;
    chk(l >= lo && l <= hi, "R6 gated low length", l, lo);
    chk(bl == 0, "R5 busy held through gated low", bl, 0);
    checkRestart(nd);
    curDiv = nd;
  endtask

  task automatic doubleChange(int a, int b, bit lng, int inHold);
    int h = lng ? LHOLD : SHOLD;
    int l, bl, lo, hi, early;
    minHalf = ((curDiv < a ? curDiv : a) < b ? (curDiv < a ? curDiv : a) : b) + 1;
    longHold = lng;
    drive; divField = DIV_W'(a);
    @(negedge clk);
    @(negedge clk);
    waitLevel(1'b0);
    early = 0;
    for (int i = 0; i < inHold; i++) begin
      if (pllClk !== 1'b0) early++;
      @(negedge clk);
    end
    chk(early == 0, "R5 output low early in hold", early, 0);
    drive; divField = DIV_W'(b);
    @(negedge clk);
    countLevel(1'b0, l, bl);
    lo = (h - 1) * REFP + b;
    hi = h * REFP + b + 8;
    chk(l >= lo && l <= hi, "R9 hold restarted by second change", l, lo);
    checkRestart(b);
    curDiv = b;
  endtask

  initial begin
    int l, bl, h, bad;
    repeat (3) @(negedge clk);
    chk(pllClk === 1'b0, "R1 clock low in reset", int'(pllClk), 0);
    chk(gateBusy === 1'b0, "R1 busy low in reset", int'(gateBusy), 0);
    drive; rstN = 1'b1;
    @(negedge clk);
    countLevel(1'b0, l, bl);
    chk(l == RDIV + 1, "R1 first low after reset", l, RDIV + 1);
    chk(gateBusy === 1'b0, "R1 busy low after reset", int'(gateBusy), 0);

    // Direct loads while inactive, all divide values
    for (int d = 0; d < (1 << DIV_W); d++) begin
      minHalf = ((curDiv < d) ? curDiv : d) + 1;
      drive; pllActive = 1'b0; divField = DIV_W'(d);
      bad = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (gateBusy !== 1'b0) bad++;
      end
      chk(bad == 0, "R3 no busy on inactive load", bad, 0);
      drive; pllActive = 1'b1;
      @(negedge clk);
      waitLevel(1'b0);
      waitLevel(1'b1);
      countLevel(1'b1, h, bl);
      chk(h == d + 1, "R2 high phase length", h, d + 1);
      countLevel(1'b0, l, bl);
      chk(l == d + 1, "R2 low phase length", l, d + 1);
      chk(gateBusy === 1'b0, "R3 busy low after reactivation", int'(gateBusy), 0);
      curDiv = d;
    end

    // Active changes, both hold lengths, varied phases
    for (int lg = 0; lg < 2; lg++) begin
      for (int k = 0; k < 4; k++) begin
        int nd = (curDiv * 5 + 3 + k) % (1 << DIV_W);
        if (nd == curDiv) nd = (nd + 1) % (1 << DIV_W);
        repeat (k) @(negedge clk);
        activeChange(nd, lg[0]);
      end
    end

    doubleChange((curDiv + 2) % 8, (curDiv + 5) % 8, 1'b1, 30);
    doubleChange((curDiv + 3) % 8, (curDiv + 1) % 8, 1'b0, 6);

    repeat (10) @(negedge clk);
    chk(runtErr == 0, "R7 no runt phases", runtErr, 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule